// File: doc/BRIEF.md
# Serial Management Interface Master (Clause 22)

This block lets a MAC read and write the registers of an attached PHY over the two-wire serial management interface. A request carries a read/write flag, a 5-bit PHY address, a register address and 16 bits of write data. The block then runs one complete transaction on the wire. It generates the management clock from the system clock through a divider whose half-period is set at an input port. It drives the bidirectional data line through a separate output value and output enable, so the pad sits outside the block.

Every transaction opens with an extended preamble of 33 ones. A write shifts out a complete 32-bit frame and then clocks two more cycles with the line released. A read shifts out a 14-bit header and then releases the line for 19 clock cycles: turnaround, 16 data bits and one trailing idle bit. At the end of a read the block presents the 16 bits that came before the last sampled bit, together with a one-cycle done strobe. If any register address bit above bit 4 is set, the request is refused with an error strobe and nothing is driven on the wire.

Top module: `mgmt_master`

## Requirements
- R1: The management clock idles low. While a transaction runs, each low half and each high half lasts `clk_div_i` system clock cycles, and a divider value of 0 acts as 1.
- R2: Each transaction starts with 33 management clock cycles in which the data output is 1 and the output enable is 1.
- R3: A read header follows the preamble as 14 bits, MSB first: `0`,`1`, then opcode `1`,`0`, then the 5-bit PHY address, then the low 5 bits of the register address.
- R4: The data output and output enable change only while the management clock is low, and they hold steady through each high half.
- R5: After the read header come 19 released cycles, and `mdio_i` is sampled once per rising edge. Of the 19 samples (first is index 18, last is index 0), the returned value is samples 16 down to 1. It appears on `rd_data_o` in the same cycle as `done_o`.
- R6: A write drives 32 bits MSB first after the preamble: `0`,`1`, opcode `0`,`1`, PHY address, register address, `1`,`0`, then the 16 data bits. Two released cycles follow, and then `done_o`.
- R7: A request with any register address bit above bit 4 set raises `err_o` for one cycle. It leaves `busy_o` low and produces no management clock edge.
- R8: `busy_o` goes high in the cycle after a request is accepted and falls in the same cycle that `done_o` pulses. Requests made while busy are ignored and do not disturb the frame in flight.
- R9: The output enable is low across every released cycle (the 19 read input cycles and the 2 write tail cycles) and while idle.
- R10: A read transaction has exactly 66 rising clock edges and a write has exactly 67.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div_i | input | DIV_W | Half-period of the management clock in system cycles |
| req_i | input | 1 | Request strobe |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | REG_W | Register address; only values below 32 are legal |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction strobe |
| err_o | output | 1 | One-cycle strobe for a refused request |
| rd_data_o | output | 16 | Register value returned by the last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A small PHY model in the bench records the data line at every rising management clock edge and returns a chosen 19-bit pattern during read turnaround and data. Reads are run with alternating and with edge-heavy data patterns. This separates the correct 16-bit window from windows off by one on either side, and it also exposes a wrong bit order. Writes with different addresses and data confirm the frame layout, the opcode, the turnaround and the released tail. Dividers of 1, 2 and 5 test the half-period count. A request issued mid-transaction and a request with an illegal register address check the ignore and refuse paths.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PHY_W  = 5;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic              rd;
    logic [PHY_W-1:0]  phy;
    logic [4:0]        regad;
    logic [DATA_W-1:0] wdata;
  } mgmt_req_t;
endpackage

// File: rtl/mgmt_clkgen.sv
module mgmt_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             bitend_ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             ph_q;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign wrap = (cnt_q == DIV_W'(lim - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign rise_ev   = run && !ph_q && wrap;
  assign bitend_ev = run &&  ph_q && wrap;
  assign mdc       = ph_q;

  // R1: clock sits low whenever no transaction runs
  assert_mdc_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mdc);
  // R1: counter never passes the half-period limit
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < lim));
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 33,
  parameter int RD_IN   = 19,
  parameter int WR_TAIL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mgmt_req_t         req,
  input  logic              mdc,
  input  logic              rise_ev,
  input  logic              bitend_ev,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int HDR_RD = 14;
  localparam int FR_W   = 32;
  localparam int SW     = PRE_LEN + FR_W;
  localparam int RD_TOT = PRE_LEN + HDR_RD + RD_IN;
  localparam int WR_TOT = PRE_LEN + FR_W + WR_TAIL;
  localparam int BW     = $clog2(PRE_LEN + 2 * FR_W + 4);

  logic [SW-1:0]    dsh_q, esh_q;
  logic [BW-1:0]    bitn_q;
  logic             rd_q;
  logic [RD_IN-1:0] rx_q;
  logic [FR_W-1:0]  frame, oemask;
  logic [BW-1:0]    last_bit;
  logic             in_phase;

  always_comb begin
    if (req.rd) begin
      frame  = {2'b01, 2'b10, req.phy, req.regad, 18'd0};
      oemask = {{HDR_RD{1'b1}}, {(FR_W-HDR_RD){1'b0}}};
    end else begin
      frame  = {2'b01, 2'b01, req.phy, req.regad, 2'b10, req.wdata};
      oemask = '1;
    end
  end

  assign last_bit = rd_q ? BW'(RD_TOT - 1) : BW'(WR_TOT - 1);
  assign in_phase = rd_q && (bitn_q >= BW'(PRE_LEN + HDR_RD));

  always_ff @(posedge clk) begin
    if (rst) begin
      dsh_q   <= '0;
      esh_q   <= '0;
      bitn_q  <= '0;
      rd_q    <= 1'b0;
      rx_q    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        rd_q   <= req.rd;
        bitn_q <= '0;
        dsh_q  <= {{PRE_LEN{1'b1}}, frame};
        esh_q  <= {{PRE_LEN{1'b1}}, oemask};
      end else if (busy) begin
        if (rise_ev && in_phase)
          rx_q <= {rx_q[RD_IN-2:0], mdio_i};
        if (bitend_ev) begin
          dsh_q  <= {dsh_q[SW-2:0], 1'b0};
          esh_q  <= {esh_q[SW-2:0], 1'b0};
          bitn_q <= bitn_q + BW'(1);
          if (bitn_q == last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (rd_q) rd_data <= rx_q[16:1];
          end
        end
      end
    end
  end

  assign mdio_o  = dsh_q[SW-1];
  assign mdio_oe = esh_q[SW-1];

  // R4: line held steady while the clock is high
  assert_stable_high_R4: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R9: released during read input phase
  assert_released_input_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && in_phase) |-> !mdio_oe);
  // R9: released when idle
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  // R8: done only ends a busy period
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R8: a request while busy leaves the transaction running
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !bitend_ev) |=> (busy && $stable(rd_q)));
endmodule

// File: rtl/mgmt_master.sv
module mgmt_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int REG_W   = 8,
  parameter int PRE_LEN = 33,
  parameter int RD_IN   = 19,
  parameter int WR_TAIL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              req_i,
  input  logic              req_rd_i,
  input  logic [PHY_W-1:0]  req_phy_i,
  input  logic [REG_W-1:0]  req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int HI_W = (REG_W > 5) ? REG_W - 5 : 1;

  mgmt_req_t req;
  logic      bad_reg, start;
  logic      rise_ev, bitend_ev;

  generate
    if (REG_W > 5) begin : g_wide
      assign bad_reg = |req_reg_i[REG_W-1:5];
    end else begin : g_narrow
      logic [HI_W-1:0] unused_hi;
      assign unused_hi = '0;
      assign bad_reg   = 1'b0;
    end
  endgenerate

  assign req.rd    = req_rd_i;
  assign req.phy   = req_phy_i;
  assign req.regad = req_reg_i[4:0];
  assign req.wdata = req_wdata_i;
  assign start     = req_i && !bad_reg;

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= req_i && bad_reg && !busy_o;
  end

  mgmt_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst(rst), .run(busy_o), .div(clk_div_i),
    .mdc(mdc_o), .rise_ev(rise_ev), .bitend_ev(bitend_ev)
  );

  mgmt_seq #(.PRE_LEN(PRE_LEN), .RD_IN(RD_IN), .WR_TAIL(WR_TAIL)) seq_i (
    .clk(clk), .rst(rst), .start(start), .req(req), .mdc(mdc_o),
    .rise_ev(rise_ev), .bitend_ev(bitend_ev), .mdio_i(mdio_i),
    .busy(busy_o), .done(done_o), .rd_data(rd_data_o),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe_o)
  );

  // R7: a refused request never starts a transaction
  assert_reject_no_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (req_i && bad_reg && !busy_o) |=> (!busy_o && err_o && !mdc_o));
endmodule

// File: tb/mgmt_master_tb_top.sv
module mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_div_i = 8'd2;
  logic        req_i = 1'b0, req_rd_i = 1'b0;
  logic [4:0]  req_phy_i = '0;
  logic [7:0]  req_reg_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rd_data_o;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  logic rec_o [0:127];
  logic rec_oe[0:127];
  int   nrise, half_bad, r4_bad;
  logic [15:0] got_data;
  logic        hung;

  always #5 clk = ~clk;

  mgmt_master dut_i (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [7:0] rg,
                         input logic [15:0] wd, input logic [7:0] dv,
                         input logic [18:0] pat, input bit inject);
    logic prev; int runlen; bit seen; bit injected;
    nrise = 0; half_bad = 0; r4_bad = 0; hung = 1'b1; injected = 0;
    seen = 0; runlen = 0;
    @(negedge clk);
    clk_div_i = dv; req_rd_i = rd; req_phy_i = phy; req_reg_i = rg;
    req_wdata_i = wd; req_i = 1'b1; mdio_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R8", "busy after accept", busy_o, 1);
    prev = mdc_o;
    for (int it = 0; it < 20000; it++) begin
      @(negedge clk);
      req_i = 1'b0;
      if (mdc_o != prev) begin
        if (seen && runlen != ((dv == 0) ? 1 : dv)) half_bad++;
        seen = 1; runlen = 1;
        if (mdc_o) begin
          rec_o[nrise] = mdio_o; rec_oe[nrise] = mdio_oe_o; nrise++;
        end else begin
          if (nrise >= 47 && nrise <= 65) mdio_i = pat[18 - (nrise - 47)];
          else mdio_i = 1'b1;
        end
      end else begin
        runlen++;
        if (mdc_o && nrise > 0 &&
            (rec_o[nrise-1] != mdio_o || rec_oe[nrise-1] != mdio_oe_o)) r4_bad++;
      end
      prev = mdc_o;
      if (inject && !injected && nrise == 20) begin
        injected = 1; req_i = 1'b1; req_rd_i = ~rd; req_phy_i = ~phy;
        req_reg_i = 8'h1F; req_wdata_i = ~wd;
      end
      if (done_o) begin
        got_data = rd_data_o; hung = 1'b0;
        break;
      end
    end
    chk(!hung, "R8", "done reached", hung, 0);
    chk(half_bad == 0, "R1", "half periods off", half_bad, 0);
    chk(r4_bad == 0, "R4", "changes during high", r4_bad, 0);
    chk(busy_o == 1'b0 && mdc_o == 1'b0, "R8", "idle after done",
        {busy_o, mdc_o}, 0);
  endtask

  task automatic check_pre();
    int bad = 0;
    for (int i = 0; i < 33; i++) if (rec_o[i] !== 1'b1 || rec_oe[i] !== 1'b1) bad++;
    chk(bad == 0, "R2", "preamble bits wrong", bad, 0);
  endtask

  task automatic test_read(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] data, input logic [7:0] dv, input bit inj);
    logic [13:0] hdr; logic [18:0] pat; int bad = 0; int oeb = 0;
    hdr = {2'b01, 2'b10, phy, rg};
    pat = {1'b1, 1'b0, data, 1'b1};
    run_txn(1'b1, phy, {3'b0, rg}, 16'h0, dv, pat, inj);
    check_pre();
    for (int i = 0; i < 14; i++) if (rec_o[33+i] !== hdr[13-i] || rec_oe[33+i] !== 1'b1) bad++;
    chk(bad == 0, "R3", "read header bits wrong", bad, 0);
    for (int i = 47; i < 66; i++) if (rec_oe[i] !== 1'b0) oeb++;
    chk(oeb == 0, "R9", "oe high in read input", oeb, 0);
    chk(nrise == 66, "R10", "read edges", nrise, 66);
    chk(got_data == data, "R5", "read data", got_data, data);
  endtask

  task automatic test_write(input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [7:0] dv, input bit inj);
    logic [31:0] fr; int bad = 0;
    fr = {2'b01, 2'b01, phy, rg, 2'b10, wd};
    run_txn(1'b0, phy, {3'b0, rg}, wd, dv, 19'h0, inj);
    check_pre();
    for (int i = 0; i < 32; i++) if (rec_o[33+i] !== fr[31-i] || rec_oe[33+i] !== 1'b1) bad++;
    chk(bad == 0, "R6", "write frame bits wrong", bad, 0);
    chk(rec_oe[65] === 1'b0 && rec_oe[66] === 1'b0, "R9", "write tail released",
        {rec_oe[65], rec_oe[66]}, 0);
    chk(nrise == 67, "R10", "write edges", nrise, 67);
  endtask

  task automatic test_reject();
    int moved = 0;
    @(negedge clk);
    req_i = 1'b1; req_rd_i = 1'b1; req_reg_i = 8'h25; req_phy_i = 5'h3;
    @(negedge clk);
    req_i = 1'b0;
    chk(err_o == 1'b1, "R7", "err strobe", err_o, 1);
    chk(busy_o == 1'b0, "R7", "busy after refuse", busy_o, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mdc_o || busy_o || mdio_oe_o) moved++;
    end
    chk(moved == 0, "R7", "wire activity after refuse", moved, 0);
    chk(err_o == 1'b0, "R7", "err one cycle", err_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mdc_o == 0 && mdio_oe_o == 0 && busy_o == 0 && done_o == 0, "R1",
        "reset state", {mdc_o, mdio_oe_o, busy_o, done_o}, 0);
    test_read(5'h01, 5'h02, 16'hA5C3, 8'd2, 1'b0);
    test_read(5'h1E, 5'h1F, 16'h8001, 8'd1, 1'b0);
    test_write(5'h15, 5'h04, 16'h01E1, 8'd2, 1'b0);
    test_write(5'h0A, 5'h11, 16'hFFFE, 8'd5, 1'b1);
    test_read(5'h07, 5'h00, 16'h3C5A, 8'd0, 1'b1);
    test_reject();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule